// File: doc/BRIEF.md
# Serial Bit Clock Source Selector with Internal Generator

This block sits at the front of a serial audio receiver that runs from a master clock. It watches the incoming bit clock against the frame (left/right) clock and decides whether a usable bit clock is being driven from outside. When one is present, that clock is passed to the receiver. When none is present, the block makes its own bit clock by dividing the master clock.

The internal divide ratio depends on two static selects: the number of master clocks per frame, and the serial data format. Only the number of bit clocks per frame matters to the data timing, and that number depends on both selects. The internal clock restarts on every frame-clock edge, so the data timing is the same as with an outside bit clock that is locked to the frame clock.

Switching between the two sources uses hysteresis. A burst of external edges within one frame phase selects the external source. Two whole silent frame periods select the internal source again. Both asynchronous inputs pass through two-flop synchronizers in the master clock domain.

Top module: `sclk_mode_gen`

## Requirements
- R1: While reset is active and after it is released, `ext_mode` is 0 and the edge and idle counts are cleared. `bclk_out` is 0 during reset.
- R2: `ext_mode` goes to 1 on the 16th rising edge of `bclk_ext` seen inside one frame-clock phase. A 15th edge is not enough. The flag changes on the third master-clock rising edge after the input edge.
- R3: The count of external edges is cleared on every `lrck` transition, whether rising or falling. Edges from two different phases never add up to 16.
- R4: In external mode, `ext_mode` returns to 0 once two complete `lrck` periods, measured from rising edge to rising edge, pass with no `bclk_ext` rising edge. The flag holds through the first silent period.
- R5: In external mode, `bclk_out` follows the synchronized `bclk_ext`, one rising edge for every external rising edge.
- R6: In internal mode, `bclk_out` gives a fixed number of rising edges per frame. The number is 48 when `ratio_sel` is 1 (192 master clocks per frame) or 3 (384). Otherwise it is 64 for `fmt_sel` 1 (left justified) or 2 (right justified, 24-bit), and 32 for `fmt_sel` 0 (I2S) or 3 (right justified, 16-bit). The `ratio_sel` codes are 0=128, 1=192, 2=256, 3=384 and 4=512; codes 5 to 7 act as 512.
- R7: In internal mode, the divider restarts on each synchronized `lrck` edge. `bclk_out` is low at the fourth master-clock rising edge after the input edge. It goes high D/2 master clocks later, where D is the master clocks per frame divided by the bits per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lrck | input | 1 | Frame (left/right) clock, asynchronous |
| bclk_ext | input | 1 | External bit clock, asynchronous, may be absent |
| fmt_sel | input | 2 | Serial format: 0 I2S, 1 left justified, 2 right justified 24-bit, 3 right justified 16-bit |
| ratio_sel | input | 3 | Master clocks per frame: 0=128, 1=192, 2=256, 3=384, 4..7=512 |
| ext_mode | output | 1 | 1 when the external bit clock is selected |
| bclk_out | output | 1 | Selected bit clock, registered |

## Verification
The assertions are checked on every cycle. They check that the edge count never passes its limit and is cleared after every frame edge. They check that the mode flag rises only when the 15th counted edge meets a fresh external rising edge, and falls only at a frame rising edge that ends the second silent period. They also check that the divider is at zero with its clock low right after each frame edge. Some behaviour only the bench scenarios can show: the edge count per frame for every format and ratio pair, the exact latency of the first high half after a frame edge, and that the external clock reaches the output. The bench scenarios also cover the burst patterns that almost reach the limit, or that cross a frame edge and so must not switch modes.

// File: rtl/scm_pkg.sv
package scm_pkg;

  localparam int DIV_W = 5;

  localparam logic [2:0] RAT_128 = 3'd0;
  localparam logic [2:0] RAT_192 = 3'd1;
  localparam logic [2:0] RAT_256 = 3'd2;
  localparam logic [2:0] RAT_384 = 3'd3;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LEFT = 2'd1,
    FMT_RJ24 = 2'd2,
    FMT_RJ16 = 2'd3
  } fmt_e;

  // Master clocks per internal bit clock for a format / ratio pair.
  function automatic logic [DIV_W-1:0] bclk_divisor(input logic [1:0] fmt,
                                                     input logic [2:0] ratio);
    logic [DIV_W-1:0] d;
    logic             wide;
    logic             triple;
    wide   = (fmt == FMT_LEFT) || (fmt == FMT_RJ24);
    triple = (ratio == RAT_192) || (ratio == RAT_384);
    case (ratio)
      RAT_128: d = DIV_W'(4);
      RAT_192: d = DIV_W'(4);
      RAT_256: d = DIV_W'(8);
      RAT_384: d = DIV_W'(8);
      default: d = DIV_W'(16);
    endcase
    if (wide && !triple) d = d >> 1;
    return d;
  endfunction

endpackage

// File: rtl/scm_sync.sv
module scm_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/scm_mode_ctl.sv
module scm_mode_ctl #(
  parameter int EDGE_THRESH  = 16,
  parameter int IDLE_PERIODS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lr_s,
  input  logic bx_s,
  output logic frame_edge,
  output logic ext_mode
);

  localparam int CW = $clog2(EDGE_THRESH + 1);
  localparam int IW = $clog2(IDLE_PERIODS + 1);

  logic          lr_q, bx_q;
  logic          lr_rise, ext_rise;
  logic [CW-1:0] edge_cnt, edge_cnt_nxt;
  logic [IW-1:0] idle_cnt, idle_cnt_nxt;
  logic          seen, seen_nxt;
  logic          mode_nxt;
  logic          hit, drop;

  assign frame_edge = lr_s ^ lr_q;
  assign lr_rise    = lr_s & ~lr_q;
  assign ext_rise   = bx_s & ~bx_q;

  // edge counter, cleared on any frame transition
  always_comb begin
    edge_cnt_nxt = edge_cnt;
    if (frame_edge)
      edge_cnt_nxt = ext_rise ? CW'(1) : '0;
    else if (ext_rise && edge_cnt != CW'(EDGE_THRESH))
      edge_cnt_nxt = edge_cnt + CW'(1);
  end

  // idle period counter with per-period seen flag
  always_comb begin
    seen_nxt     = seen;
    idle_cnt_nxt = idle_cnt;
    if (lr_rise) begin
      seen_nxt = ext_rise;
      if (seen || ext_rise)
        idle_cnt_nxt = '0;
      else if (idle_cnt != IW'(IDLE_PERIODS))
        idle_cnt_nxt = idle_cnt + IW'(1);
    end else if (ext_rise) begin
      seen_nxt     = 1'b1;
      idle_cnt_nxt = '0;
    end
  end

  always_comb begin
    hit  = ext_rise && !frame_edge && (edge_cnt == CW'(EDGE_THRESH - 1));
    drop = lr_rise && !seen && !ext_rise && (idle_cnt == IW'(IDLE_PERIODS - 1));
    mode_nxt = ext_mode;
    if (!ext_mode && hit)
      mode_nxt = 1'b1;
    else if (ext_mode && drop)
      mode_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q     <= 1'b0;
      bx_q     <= 1'b0;
      edge_cnt <= '0;
      idle_cnt <= '0;
      seen     <= 1'b0;
      ext_mode <= 1'b0;
    end else begin
      lr_q     <= lr_s;
      bx_q     <= bx_s;
      edge_cnt <= edge_cnt_nxt;
      idle_cnt <= idle_cnt_nxt;
      seen     <= seen_nxt;
      ext_mode <= mode_nxt;
    end
  end

  // R2: entry only when the counted run completes
  a_r2_entry_on_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_mode) |-> ($past(edge_cnt) == CW'(EDGE_THRESH - 1) && $past(ext_rise)));

  // R2: count never passes its limit
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= CW'(EDGE_THRESH));

  // R3: count restarts after every frame transition
  a_r3_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    frame_edge |=> (edge_cnt <= CW'(1)));

  // R4: exit only at a frame rising edge ending the last silent period
  a_r4_exit_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_mode) |-> ($past(lr_rise) && $past(idle_cnt) == IW'(IDLE_PERIODS - 1)));

endmodule

// File: rtl/scm_bclk_div.sv
module scm_bclk_div #(
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_edge,
  input  logic [DW-1:0] div_sel,
  output logic          bclk_int
);

  logic [DW-1:0] cnt, cnt_nxt;
  logic [DW-1:0] half;
  logic          bclk_nxt;

  always_comb begin
    half = div_sel >> 1;
    if (frame_edge || cnt >= div_sel - DW'(1))
      cnt_nxt = '0;
    else
      cnt_nxt = cnt + DW'(1);
    bclk_nxt = (cnt_nxt >= half) && !frame_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      bclk_int <= 1'b0;
    end else begin
      cnt      <= cnt_nxt;
      bclk_int <= bclk_nxt;
    end
  end

  // R7: phase restarts low after every frame edge
  a_r7_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_edge |=> (cnt == '0 && !bclk_int));

  // R6: counter stays inside the selected period while the select holds
  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(div_sel) && $past(cnt) < div_sel) |-> (cnt < div_sel));

endmodule

// File: rtl/sclk_mode_gen.sv
module sclk_mode_gen #(
  parameter int SYNC_STAGES  = 2,
  parameter int EDGE_THRESH  = 16,
  parameter int IDLE_PERIODS = 2
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       lrck,
  input  logic       bclk_ext,
  input  logic [1:0] fmt_sel,
  input  logic [2:0] ratio_sel,
  output logic       ext_mode,
  output logic       bclk_out
);

  import scm_pkg::*;

  logic                   rst_s_n;
  logic                   lr_s, bx_s;
  logic                   frame_edge;
  logic                   bclk_int;
  logic [DIV_W-1:0]       div_sel;
  logic                   bclk_nxt;

  scm_sync #(.STAGES(2), .WIDTH(1)) u_rst_sync (
    .clk   (mclk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_s_n)
  );

  scm_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_in_sync (
    .clk   (mclk),
    .rst_n (rst_s_n),
    .d     ({lrck, bclk_ext}),
    .q     ({lr_s, bx_s})
  );

  scm_mode_ctl #(.EDGE_THRESH(EDGE_THRESH), .IDLE_PERIODS(IDLE_PERIODS)) u_mode (
    .clk        (mclk),
    .rst_n      (rst_s_n),
    .lr_s       (lr_s),
    .bx_s       (bx_s),
    .frame_edge (frame_edge),
    .ext_mode   (ext_mode)
  );

  assign div_sel = bclk_divisor(fmt_sel, ratio_sel);

  scm_bclk_div #(.DW(DIV_W)) u_div (
    .clk        (mclk),
    .rst_n      (rst_s_n),
    .frame_edge (frame_edge),
    .div_sel    (div_sel),
    .bclk_int   (bclk_int)
  );

  always_comb bclk_nxt = ext_mode ? bx_s : bclk_int;

  always_ff @(posedge mclk or negedge rst_s_n) begin
    if (!rst_s_n) bclk_out <= 1'b0;
    else          bclk_out <= bclk_nxt;
  end

  // R1: reset leaves the block in internal mode
  a_r1_reset_internal: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(rst_s_n) |-> !ext_mode);

endmodule

// File: tb/test_sclk_mode_gen.sv
module test_sclk_mode_gen;

  logic       mclk = 1'b0;
  logic       rst_n;
  logic       lrck;
  logic       bclk_ext;
  logic [1:0] fmt_sel;
  logic [2:0] ratio_sel;
  logic       ext_mode;
  logic       bclk_out;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  int hf_len = 128, hf_pos = 0;
  bit lr_run = 1'b0;
  bit ext_on = 1'b0;
  int ext_half = 2, ext_pos = 0;
  int rise_cnt = 0;
  logic last_b = 1'b0;
  bit lr_rose = 1'b0;

  always #2.5 mclk = ~mclk;

  sclk_mode_gen i_sclk_mode_gen (
    .mclk      (mclk),
    .rst_n     (rst_n),
    .lrck      (lrck),
    .bclk_ext  (bclk_ext),
    .fmt_sel   (fmt_sel),
    .ratio_sel (ratio_sel),
    .ext_mode  (ext_mode),
    .bclk_out  (bclk_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge mclk);
    if (bclk_out && !last_b) rise_cnt++;
    last_b  = bclk_out;
    lr_rose = 1'b0;
    if (lr_run) begin
      hf_pos++;
      if (hf_pos >= hf_len) begin
        hf_pos = 0;
        lrck = ~lrck;
        lr_rose = lrck;
      end
    end
    if (ext_on) begin
      ext_pos++;
      if (ext_pos >= ext_half) begin
        ext_pos = 0;
        bclk_ext = ~bclk_ext;
      end
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      bclk_ext = 1'b1; steps(2);
      bclk_ext = 1'b0; steps(2);
    end
  endtask

  task automatic wait_lr_rise();
    do step(); while (!lr_rose);
  endtask

  function automatic int mpf(input int r);
    case (r)
      0: return 128;
      1: return 192;
      2: return 256;
      3: return 384;
      default: return 512;
    endcase
  endfunction

  function automatic int bpf(input int f, input int r);
    if (r == 1 || r == 3) return 48;
    if (f == 1 || f == 2) return 64;
    return 32;
  endfunction

  initial begin
    repeat (200000) @(posedge mclk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lrck = 1'b0; bclk_ext = 1'b0;
    fmt_sel = 2'd1; ratio_sel = 3'd2;
    repeat (5) @(negedge mclk);
    chk(ext_mode == 1'b0, "R1", "ext_mode in reset", ext_mode, 0);
    chk(bclk_out == 1'b0, "R1", "bclk_out in reset", bclk_out, 0);
    rst_n = 1'b1;
    steps(10);
    chk(ext_mode == 1'b0, "R1", "ext_mode after release", ext_mode, 0);

    // R2: 15 edges in a phase do not switch
    pulses(15); steps(2);
    chk(ext_mode == 1'b0, "R2", "mode after 15 edges", ext_mode, 0);
    // R3: count cleared on rising and on falling frame edges
    lrck = 1'b1; steps(4);
    pulses(10);
    chk(ext_mode == 1'b0, "R3", "mode after rise clear", ext_mode, 0);
    lrck = 1'b0; steps(4);
    pulses(10);
    chk(ext_mode == 1'b0, "R3", "mode after fall clear", ext_mode, 0);
    // R2: 16th edge in one phase switches
    lrck = 1'b1; steps(4);
    pulses(15);
    chk(ext_mode == 1'b0, "R2", "mode after 15 of new phase", ext_mode, 0);
    pulses(1);
    chk(ext_mode == 1'b1, "R2", "mode after 16 edges", ext_mode, 1);

    // R5: external clock passed through, 64 per 256-cycle frame
    hf_len = 128; hf_pos = 0; lrck = 1'b0; bclk_ext = 1'b0; ext_pos = 0; ext_half = 2;
    lr_run = 1'b1; ext_on = 1'b1;
    steps(512);
    rise_cnt = 0;
    steps(256);
    chk(rise_cnt == 64, "R5", "external rises per frame", rise_cnt, 64);
    chk(ext_mode == 1'b1, "R4", "mode held with edges", ext_mode, 1);

    // R4: two silent periods return to internal
    wait_lr_rise();
    ext_on = 1'b0; bclk_ext = 1'b0;
    steps(256);
    chk(ext_mode == 1'b1, "R4", "mode after one silent period", ext_mode, 1);
    steps(256 - 4);
    chk(ext_mode == 1'b1, "R4", "mode just before second period", ext_mode, 1);
    steps(8);
    chk(ext_mode == 1'b0, "R4", "mode after two silent periods", ext_mode, 0);
    steps(20);
    rise_cnt = 0;
    steps(256);
    chk(rise_cnt == 64, "R6", "internal rises after revert", rise_cnt, 64);

    // R6/R7 sweep over every format and ratio code
    for (int f = 0; f < 4; f++) begin
      for (int r = 0; r < 8; r++) begin
        int m, b, half;
        if (r > 4 && f != 0) continue;
        m = mpf(r); b = bpf(f, r); half = (m / b) / 2;
        fmt_sel = f[1:0]; ratio_sel = r[2:0];
        hf_pos = 0; hf_len = m / 2;
        steps(2 * m);
        wait_lr_rise();
        steps(4);
        chk(bclk_out == 1'b0, "R7", $sformatf("low after edge f%0d r%0d", f, r), bclk_out, 0);
        steps(half);
        chk(bclk_out == 1'b1, "R7", $sformatf("high after half f%0d r%0d", f, r), bclk_out, 1);
        rise_cnt = 0;
        steps(2 * m);
        chk(rise_cnt == 2 * b, "R6", $sformatf("rises in two frames f%0d r%0d", f, r),
            rise_cnt, 2 * b);
        chk(ext_mode == 1'b0, "R6", "mode stays internal", ext_mode, 0);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule